// File: doc/BRIEF.md
# Binary autocorrelation matrix accumulator

The block builds, over a window of bit periods, the autocorrelation matrix of the antipodal training or tracking symbols that a multiuser channel estimator needs. Each accepted bit period brings a vector of 2K one-bit symbols: the present bit of each of K users and the bit each user sent one period earlier. The logic bit 1 means +1 and 0 means -1, so the product of two symbols is the XNOR of their bits. That XNOR sets the direction of a small saturating up/down counter for each matrix entry. No multiplier is used. All entries move together in the same clock edge.

The matrix is symmetric, so only the entries on and above the diagonal are stored. A diagonal entry is the square of a symbol, so it always counts up and needs no XNOR. A source select picks known pilot bits during training or fed-back detected bits during tracking. A window-start pulse zeroes the matrix and opens a window of `WIN_LEN` bits. A clear pulse zeroes the matrix and returns the block to idle. A combinational read port returns any entry by row and column, with the two indices interchangeable.

The controller has three states. `ST_IDLE` is entered from reset and on clear. `ST_ACCUM` is entered on window start from any state, and a further start restarts it. `ST_FULL` is entered from `ST_ACCUM` when the last bit of the window is accepted. Clear leads from every state to `ST_IDLE`, and start leads from `ST_FULL` back to `ST_ACCUM`.

Top module: `bitcorr_accum`

## Requirements
- R1: After reset every entry reads 0, and `win_active` and `win_full` are low.
- R2: Symbol index s in 0..K-1 is the current bit of user s, and index K+s is that user's previous bit. Bit 1 means +1 and bit 0 means -1. Each accepted bit moves every off-diagonal entry (i,j) by +1 when bits i and j are equal and by -1 when they differ.
- R3: Each accepted bit adds +1 to every diagonal entry (i,i).
- R4: Entries are signed 8-bit values. They hold at +127 instead of stepping up and hold at -128 instead of stepping down.
- R5: With `src_sel`=0 the symbols come from `pilot_cur`/`pilot_prev`; with `src_sel`=1 they come from `det_cur`/`det_prev`. The unselected pair has no effect on any entry.
- R6: `rd_data` shows entry (`rd_row`,`rd_col`) in the same cycle, and (j,i) reads the same value as (i,j).
- R7: `win_start` zeroes every entry, sets `win_active` on the next cycle and restarts the bit count. A `sym_valid` in the same cycle is not accumulated. A start in the middle of a window discards the partial sums.
- R8: `sym_valid` changes nothing when `win_active` is low.
- R9: When the `WIN_LEN`-th bit of a window is accepted, `win_full` goes high and `win_active` goes low, and the entries then hold.
- R10: `clr` zeroes every entry and returns both status outputs to low on the next cycle. It takes priority over `win_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_start | input | 1 | Zero the matrix and open a window |
| clr | input | 1 | Zero the matrix and go idle |
| sym_valid | input | 1 | A bit period's symbols are present |
| src_sel | input | 1 | 0 selects pilot bits, 1 selects detected bits |
| pilot_cur | input | K | Pilot bits of the current period |
| pilot_prev | input | K | Pilot bits of the previous period |
| det_cur | input | K | Detected bits of the current period |
| det_prev | input | K | Detected bits of the previous period |
| rd_row | input | $clog2(2K) | Read row index |
| rd_col | input | $clog2(2K) | Read column index |
| rd_data | output | 8 | Signed entry value |
| win_active | output | 1 | Window open and accepting bits |
| win_full | output | 1 | Window has received all its bits |

## Verification
The assertions assume that `clr`, `win_start` and `sym_valid` are single-cycle, synchronous pulses. They also assume that the row and column indices stay below 2K whenever a value is read. The bench drives every control as a one-cycle pulse on the falling edge and reads only valid indices. It runs two instances at once, one with K=4 and one with K=2, and compares every entry in both orders against a software sum of products. The windows are long enough to drive entries into both saturation limits. Starts, clears and bits are also applied together in the same cycle.

// File: rtl/bcorr_pkg.sv
package bcorr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FULL  = 2'd2
    } bcorr_state_t;

    // Flat position of upper-triangle entry (lo,hi), lo <= hi, in an n x n matrix
    function automatic int tri_index(input int lo, input int hi, input int n);
        return lo * n - (lo * (lo - 1)) / 2 + (hi - lo);
    endfunction

endpackage

// File: rtl/bcorr_symsel.sv
module bcorr_symsel #(
    parameter int K = 4
) (
    input  logic             src_sel,
    input  logic [K-1:0]     pilot_cur,
    input  logic [K-1:0]     pilot_prev,
    input  logic [K-1:0]     det_cur,
    input  logic [K-1:0]     det_prev,
    output logic [2*K-1:0]   sym_vec
);

    // Index 0..K-1: current bits, K..2K-1: previous bits
    always_comb begin
        if (src_sel)
            sym_vec = {det_prev, det_cur};
        else
            sym_vec = {pilot_prev, pilot_cur};
    end

endmodule

// File: rtl/bcorr_ctrl.sv
module bcorr_ctrl
    import bcorr_pkg::*;
#(
    parameter int WIN_LEN = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_start,
    input  logic clr,
    input  logic sym_valid,
    output logic win_active,
    output logic win_full,
    output logic zero_all,
    output logic step_en
);

    localparam int BCW = $clog2(WIN_LEN + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(WIN_LEN - 1);

    bcorr_state_t state_q, state_d;
    logic [BCW-1:0] bit_cnt_q;
    logic           last_bit;

    assign last_bit = (bit_cnt_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr)            state_d = ST_IDLE;
                else if (win_start) state_d = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (clr)                        state_d = ST_IDLE;
                else if (win_start)             state_d = ST_ACCUM;
                else if (sym_valid && last_bit) state_d = ST_FULL;
            end
            ST_FULL: begin
                if (clr)            state_d = ST_IDLE;
                else if (win_start) state_d = ST_ACCUM;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        win_active = (state_q == ST_ACCUM);
        win_full   = (state_q == ST_FULL);
        zero_all   = clr | win_start;
        step_en    = sym_valid & (state_q == ST_ACCUM) & ~clr & ~win_start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_cnt_q <= '0;
        else if (zero_all)
            bit_cnt_q <= '0;
        else if (step_en)
            bit_cnt_q <= bit_cnt_q + 1'b1;
    end

endmodule

// File: rtl/bcorr_pair_cell.sv
module bcorr_pair_cell #(
    parameter int W       = 8,
    parameter bit IS_DIAG = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                zero_all,
    input  logic                step_en,
    input  logic                sym_a,
    input  logic                sym_b,
    output logic signed [W-1:0] cnt
);

    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic dir_up;

    generate
        if (IS_DIAG) begin : g_diag
            // a symbol times itself is always +1
            logic unused_syms;
            assign unused_syms = sym_a & sym_b;
            assign dir_up      = 1'b1 | unused_syms;
        end else begin : g_pair
            assign dir_up = ~(sym_a ^ sym_b);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (zero_all)
            cnt <= '0;
        else if (step_en) begin
            if (dir_up && cnt != MAXV)
                cnt <= cnt + 1'b1;
            else if (!dir_up && cnt != MINV)
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/bcorr_rdmux.sv
module bcorr_rdmux
    import bcorr_pkg::*;
#(
    parameter int N2 = 8,
    parameter int W  = 8,
    parameter int NE = N2 * (N2 + 1) / 2,
    parameter int IW = $clog2(N2)
) (
    input  logic [NE*W-1:0]     cnt_flat,
    input  logic [IW-1:0]       rd_row,
    input  logic [IW-1:0]       rd_col,
    output logic signed [W-1:0] rd_data
);

    int lo, hi, pos;

    always_comb begin
        if (rd_row <= rd_col) begin
            lo = int'(rd_row);
            hi = int'(rd_col);
        end else begin
            lo = int'(rd_col);
            hi = int'(rd_row);
        end
        pos = tri_index(lo, hi, N2);
        if (hi < N2)
            rd_data = cnt_flat[pos*W +: W];
        else
            rd_data = '0;
    end

endmodule

// File: rtl/bitcorr_accum.sv
module bitcorr_accum
    import bcorr_pkg::*;
#(
    parameter int K       = 4,
    parameter int W       = 8,
    parameter int WIN_LEN = 160,
    localparam int N2     = 2 * K,
    localparam int IW     = $clog2(N2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_start,
    input  logic                clr,
    input  logic                sym_valid,
    input  logic                src_sel,
    input  logic [K-1:0]        pilot_cur,
    input  logic [K-1:0]        pilot_prev,
    input  logic [K-1:0]        det_cur,
    input  logic [K-1:0]        det_prev,
    input  logic [IW-1:0]       rd_row,
    input  logic [IW-1:0]       rd_col,
    output logic signed [W-1:0] rd_data,
    output logic                win_active,
    output logic                win_full
);

    localparam int NE = N2 * (N2 + 1) / 2;

    logic [N2-1:0]   sym_vec;
    logic            zero_all;
    logic            step_en;
    logic [NE*W-1:0] cnt_flat;

    bcorr_symsel #(.K(K)) u_symsel (
        .src_sel    (src_sel),
        .pilot_cur  (pilot_cur),
        .pilot_prev (pilot_prev),
        .det_cur    (det_cur),
        .det_prev   (det_prev),
        .sym_vec    (sym_vec)
    );

    bcorr_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_start  (win_start),
        .clr        (clr),
        .sym_valid  (sym_valid),
        .win_active (win_active),
        .win_full   (win_full),
        .zero_all   (zero_all),
        .step_en    (step_en)
    );

    generate
        for (genvar i = 0; i < N2; i++) begin : g_row
            for (genvar j = i; j < N2; j++) begin : g_col
                localparam int POS = tri_index(i, j, N2);
                logic signed [W-1:0] cell_cnt;
                bcorr_pair_cell #(.W(W), .IS_DIAG(i == j)) u_cell (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .zero_all (zero_all),
                    .step_en  (step_en),
                    .sym_a    (sym_vec[i]),
                    .sym_b    (sym_vec[j]),
                    .cnt      (cell_cnt)
                );
                assign cnt_flat[POS*W +: W] = cell_cnt;
            end
        end
    endgenerate

    bcorr_rdmux #(.N2(N2), .W(W), .NE(NE), .IW(IW)) u_rdmux (
        .cnt_flat (cnt_flat),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/bitcorr_accum_chk.sv
module bitcorr_accum_chk #(
    parameter int W  = 8,
    parameter int NE = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            win_start,
    input logic            win_active,
    input logic            win_full,
    input logic            step_en,
    input logic [NE*W-1:0] cnt_flat
);

    logic signed [W-1:0] diag0;
    assign diag0 = cnt_flat[W-1:0];

    localparam logic signed [W-1:0] TOPV = {1'b0, {(W-1){1'b1}}};

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_flat == '0) && !win_active && !win_full);

    // R7
    start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_start && !clr) |=> win_active && (cnt_flat == '0));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !clr && !win_start) |=> $stable(cnt_flat));

    // R8
    step_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> win_active);

    // R3
    diag_counts_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && diag0 != TOPV) |=> diag0 == W'($past(diag0) + 1'b1));

    // R4
    diag_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && diag0 == TOPV) |=> diag0 == TOPV);

    // R9
    full_excl_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_full && win_active));

endmodule

bind bitcorr_accum bitcorr_accum_chk #(.W(W), .NE(NE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .win_start  (win_start),
    .win_active (win_active),
    .win_full   (win_full),
    .step_en    (step_en),
    .cnt_flat   (cnt_flat)
);

// File: tb/bitcorr_accum_bench.sv
module bitcorr_accum_bench;

    localparam int WL = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_start = 1'b0, clr = 1'b0, sym_valid = 1'b0, src_sel = 1'b0;
    logic [3:0] pc = '0, pp = '0, dc = '0, dp = '0;
    logic [2:0] row4 = '0, col4 = '0;
    logic [1:0] row2 = '0, col2 = '0;
    logic signed [7:0] rd4, rd2;
    logic act4, full4, act2, full2;

    int checks = 0;
    int errors = 0;

    int e4 [8][8];
    int e2 [4][4];
    bit m_active = 0, m_full = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    bitcorr_accum #(.K(4), .W(8), .WIN_LEN(WL)) u_bitcorr_accum (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .clr(clr),
        .sym_valid(sym_valid), .src_sel(src_sel),
        .pilot_cur(pc), .pilot_prev(pp), .det_cur(dc), .det_prev(dp),
        .rd_row(row4), .rd_col(col4), .rd_data(rd4),
        .win_active(act4), .win_full(full4)
    );

    bitcorr_accum #(.K(2), .W(8), .WIN_LEN(WL)) u_bitcorr_accum_k2 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .clr(clr),
        .sym_valid(sym_valid), .src_sel(src_sel),
        .pilot_cur(pc[1:0]), .pilot_prev(pp[1:0]), .det_cur(dc[1:0]), .det_prev(dp[1:0]),
        .rd_row(row2), .rd_col(col2), .rd_data(rd2),
        .win_active(act2), .win_full(full2)
    );

    function automatic int sat(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_zero();
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) e4[i][j] = 0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) e2[i][j] = 0;
        m_cnt = 0;
    endtask

    // software sum of products, bit 1 = +1, bit 0 = -1
    task automatic model_bit(input logic [3:0] c, input logic [3:0] p);
        logic [7:0] v4;
        logic [3:0] v2;
        int s4 [8];
        int s2 [4];
        if (!m_active) return;
        v4 = {p, c};
        v2 = {p[1:0], c[1:0]};
        for (int i = 0; i < 8; i++) s4[i] = v4[i] ? 1 : -1;
        for (int i = 0; i < 4; i++) s2[i] = v2[i] ? 1 : -1;
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) e4[i][j] = sat(e4[i][j] + s4[i] * s4[j]);
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) e2[i][j] = sat(e2[i][j] + s2[i] * s2[j]);
        m_cnt++;
        if (m_cnt == WL) begin
            m_active = 0;
            m_full   = 1;
        end
    endtask

    task automatic send_bit(input logic src, input logic [3:0] a, input logic [3:0] b,
                            input logic [3:0] c, input logic [3:0] d);
        src_sel = src; pc = a; pp = b; dc = c; dp = d;
        sym_valid = 1'b1;
        if (src) model_bit(c, d); else model_bit(a, b);
        tick();
        sym_valid = 1'b0;
    endtask

    task automatic send_random(input logic src, input int n);
        for (int t = 0; t < n; t++)
            send_bit(src, 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
    endtask

    task automatic pulse_start(input logic with_bit);
        win_start = 1'b1;
        sym_valid = with_bit;
        pc = 4'hF; pp = 4'h0; src_sel = 1'b0;
        tick();
        win_start = 1'b0;
        sym_valid = 1'b0;
        model_zero();
        m_active = 1; m_full = 0;
    endtask

    task automatic pulse_clear(input logic with_start);
        clr = 1'b1;
        win_start = with_start;
        tick();
        clr = 1'b0;
        win_start = 1'b0;
        model_zero();
        m_active = 0; m_full = 0;
    endtask

    task automatic check_val(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic check_status(input string tag);
        check_val({tag, " win_active K=4"}, int'(act4), int'(m_active));
        check_val({tag, " win_full K=4"}, int'(full4), int'(m_full));
        check_val({tag, " win_active K=2"}, int'(act2), int'(m_active));
        check_val({tag, " win_full K=2"}, int'(full2), int'(m_full));
    endtask

    // reads every entry in both index orders (R6)
    task automatic check_matrix(input string tag);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
                row4 = 3'(r); col4 = 3'(c);
                #1;
                check_val($sformatf("%s R6 K=4 (%0d,%0d)", tag, r, c), int'(rd4), e4[r][c]);
            end
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                row2 = 2'(r); col2 = 2'(c);
                #1;
                check_val($sformatf("%s R6 K=2 (%0d,%0d)", tag, r, c), int'(rd2), e2[r][c]);
            end
    endtask

    task automatic test_reset();
        model_zero();
        check_status("R1 reset");
        check_matrix("R1 reset");
    endtask

    task automatic test_idle_ignored();
        send_random(1'b0, 5);
        check_status("R8 idle");
        check_matrix("R8 idle bits ignored");
    endtask

    task automatic test_pilot_window();
        pulse_start(1'b0);
        check_status("R7 start");
        send_random(1'b0, 25);
        check_matrix("R2 R3 pilot window");
        check_status("R2 pilot window");
    endtask

    task automatic test_detected_source();
        send_random(1'b1, 20);
        check_matrix("R5 detected source");
    endtask

    task automatic test_restart();
        send_random(1'b0, 4);
        pulse_start(1'b1);
        check_matrix("R7 restart with same-cycle bit");
        send_bit(1'b0, 4'b1010, 4'b0110, 4'b0000, 4'b1111);
        check_matrix("R7 R2 first bit after restart");
    endtask

    task automatic test_clear();
        pulse_clear(1'b0);
        check_status("R10 clear");
        check_matrix("R10 clear");
        pulse_start(1'b0);
        send_random(1'b1, 6);
        pulse_clear(1'b1);
        check_status("R10 clear over start");
        check_matrix("R10 clear over start");
        send_random(1'b0, 3);
        check_matrix("R8 after clear");
    endtask

    task automatic test_saturate_and_full();
        pulse_start(1'b0);
        for (int t = 0; t < 140; t++)
            send_bit(1'b0, 4'b1010, 4'b0110, 4'b0101, 4'b1001);
        check_matrix("R4 saturation");
        check_status("R4 mid window");
        send_random(1'b1, WL - 141);
        check_status("R9 one bit before full");
        send_random(1'b0, 1);
        check_status("R9 full");
        check_matrix("R9 last bit");
        send_random(1'b1, 5);
        check_status("R9 R8 after full");
        check_matrix("R9 R8 bits after full ignored");
        pulse_start(1'b0);
        check_status("R7 start from full");
        check_matrix("R7 start from full");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_zero();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_ignored();
        test_pilot_window();
        test_detected_source();
        test_restart();
        test_clear();
        test_saturate_and_full();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule